// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory holding 2048 bytes, arranged as eight segments of 256 bytes each. It watches a clock line and a data line that have already been brought into the system clock domain. It finds the bus conditions that open and close a transfer, takes in a select byte, a one-byte word address and data bytes, and answers by pulling the data line low through an open-drain enable. The enable is used both for acknowledges and for the zero bits of read data.

Writes go into a 16-byte page buffer and reach the array only when the transfer closes. After that the block stays busy for a fixed number of system clocks and refuses new transfers. A write-protect input drops every buffered write, while reads keep working. Reads can start at the internal address counter, or at a loaded address when a repeated start follows an address phase, and can go on for any number of bytes.

Top module: `eep_slave`

## Requirements
- R1: After synchronous reset the open-drain enable is low and the block waits for a START.
- R2: With SCL high, an SDA fall is a START and an SDA rise is a STOP. A START, repeated or not, always returns the parser to the select-byte stage, and after a STOP the enable is low.
- R3: A select byte is acknowledged only when its bits 7:4 equal 1010b. Bits 3:1 then choose the segment, and bit 0 chooses read (1) or write (0). On a mismatch the block gives no acknowledge and ignores all bytes until the next START.
- R4: For each byte it receives, the block drives the enable from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth pulse, so SDA stays low through the whole high phase of that pulse. It never drives during the eight data bits it receives.
- R5: A byte write (select with bit 0 = 0, word address, one data byte, STOP) stores the byte at address {segment, word address}.
- R6: Each data byte goes to the page slot given by the low 4 address bits, and those bits wrap within the 16-byte page. A later byte to the same slot replaces the earlier one, and all 16 slots can be written in one transfer.
- R7: Buffered bytes reach the array only on STOP. A START that arrives before the STOP throws them away.
- R8: During a read the full 11-bit address goes up by one after every byte sent, and it wraps from 2047 to 0.
- R9: A read whose select byte comes straight after the START begins at the internal counter. That counter holds the address after the last byte read, or the wrapped in-page address after the last byte written.
- R10: When the master leaves SDA high in the acknowledge slot after a read byte, the read ends and the block leaves SDA released until the next START.
- R11: While wp_i is high at STOP, the block still acknowledges address and data bytes, but it commits nothing and does not go busy. Reads are not affected.
- R12: After a committed write, the block refuses to acknowledge any select byte for BUSY_CYC system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (wired bus level) |
| wp_i | input | 1 | Write protect; high blocks all array writes |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The assertions are checked on every cycle. They cover these points: the enable changes only while SCL is low; it is low whenever the parser is idle, after any STOP, and during select bytes that arrive while busy; and a commit starts only when write protect was low. The directed scenarios cover everything that depends on data values. That includes stored bytes landing at {segment, address}, page wrap and overwrite, dropping a write on a repeated START, counter carry-over into current-address reads, 2047-to-0 rollover, and the whole busy window as the master sees it.

// File: rtl/eep_pkg.sv
// Shared types and constants for the two-wire EEPROM slave.
package eep_pkg;

    // Parser stages of one transfer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } eep_state_e;

    // Upper nibble a select byte must carry.
    localparam logic [3:0] SEL_CODE = 4'b1010;

    // Bits per byte and index of the acknowledge pulse.
    localparam logic [3:0] BIT_N    = 4'd8;
    localparam logic [3:0] ACK_SLOT = 4'd9;

endpackage

// File: rtl/eep_line_mon.sv
// Bus line monitor.
// Turns the synchronised SCL/SDA levels into single-cycle events: SCL rise,
// SCL fall, START and STOP. Assumes both inputs are already synchronous to clk
// and that SCL is slow enough for each level to last several clocks.
module eep_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Keep the previous level of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_page_buf.sv
// Page write buffer.
// Holds one byte and one valid flag per slot of a page. Slots are written by
// index; clr empties every slot. The read port is combinational and used by
// the commit sequencer. Assumes clr and wr_en are never set in the same cycle.
module eep_page_buf #(
    parameter int PG_W = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [PG_W-1:0] rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic            any_valid
);
    localparam int PG_N = 1 << PG_W;

    logic [DW-1:0] data_q  [PG_N];
    logic          valid_q [PG_N];

    for (genvar g = 0; g < PG_N; g++) begin : g_slot
        // One slot: capture a byte addressed to it, drop it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g]  <= '0;
                valid_q[g] <= 1'b0;
            end else if (clr) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PG_W'(g))) begin
                data_q[g]  <= wr_data;
                valid_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    // Reduce the slot flags to a single pending indication.
    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < PG_N; i++) begin
            any_valid = any_valid | valid_q[i];
        end
    end

endmodule

// File: rtl/eep_array.sv
// Storage array.
// One write port and one registered read port. The contents are not reset;
// only the read register is. Read data follows raddr one clock later.
module eep_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/eep_slave.sv
// Two-wire serial EEPROM slave (top).
// Parses select, word-address and data bytes, drives the open-drain enable for
// acknowledges and read bits, buffers one page of writes and commits it on
// STOP, then holds off new transfers for BUSY_CYC clocks. Assumes scl_i and
// sda_i are synchronised, SCL high/low phases last several clocks, and
// BUSY_CYC is at least the page size.
module eep_slave
    import eep_pkg::*;
#(
    parameter int SEG_W    = 3,
    parameter int PG_W     = 4,
    parameter int BUSY_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam int OFF_W  = 8;
    localparam int AW     = SEG_W + OFF_W;
    localparam int PGA_W  = AW - PG_W;
    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    logic scl_rise, scl_fall, start_det, stop_det;

    eep_state_e       state;
    logic [3:0]       cnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic             tx_act;
    logic             ack_drv;
    logic [SEG_W-1:0] seg_q;
    logic [AW-1:0]    addr_q;
    logic [PGA_W-1:0] page_q;

    logic             cm_act;
    logic [PG_W-1:0]  cm_idx;
    logic [PGA_W-1:0] cm_page;
    logic [BUSY_W-1:0] busy_cnt;
    logic             busy;
    logic             commit_go;
    logic             cm_last;

    logic             buf_clr, buf_wr, buf_vld, buf_any;
    logic [7:0]       buf_rd;
    logic [7:0]       rd_q;
    logic             sel_ok;
    logic             st_idle, st_dev;

    eep_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign busy    = (busy_cnt != '0);
    assign sel_ok  = (shreg[7:4] == SEL_CODE) && !busy;
    assign st_idle = (state == ST_IDLE);
    assign st_dev  = (state == ST_DEV);

    // Byte parser, acknowledge driver and read shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txsh    <= '0;
            tx_act  <= 1'b0;
            ack_drv <= 1'b0;
            seg_q   <= '0;
            addr_q  <= '0;
            page_q  <= '0;
        end else if (start_det) begin
            state   <= ST_DEV;
            cnt     <= '0;
            tx_act  <= 1'b0;
            ack_drv <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            tx_act  <= 1'b0;
            ack_drv <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                if (cnt < BIT_N) begin
                    cnt   <= cnt + 4'd1;
                    shreg <= {shreg[6:0], sda_i};
                end else begin
                    cnt <= ACK_SLOT;
                    if (state == ST_RDATA && sda_i) begin
                        state <= ST_IDLE;
                    end
                end
            end else if (scl_fall) begin
                if (cnt == BIT_N) begin
                    if (state == ST_RDATA) begin
                        tx_act <= 1'b0;
                        addr_q <= addr_q + 1'b1;
                    end else begin
                        case (state)
                            ST_DEV: begin
                                if (sel_ok) begin
                                    ack_drv <= 1'b1;
                                    seg_q   <= shreg[SEG_W:1];
                                    state   <= shreg[0] ? ST_RDATA : ST_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_ADDR: begin
                                ack_drv <= 1'b1;
                                addr_q  <= {seg_q, shreg};
                                page_q  <= {seg_q, shreg[7:PG_W]};
                                state   <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                ack_drv <= 1'b1;
                                addr_q  <= {addr_q[AW-1:PG_W], addr_q[PG_W-1:0] + 1'b1};
                            end
                            default: ;
                        endcase
                    end
                end else if (cnt == ACK_SLOT) begin
                    ack_drv <= 1'b0;
                    cnt     <= '0;
                    if (state == ST_RDATA) begin
                        txsh   <= rd_q;
                        tx_act <= 1'b1;
                    end
                end else if (state == ST_RDATA && cnt != '0) begin
                    txsh <= {txsh[6:0], 1'b0};
                end
            end
        end
    end

    assign sda_oe_o = ack_drv | (tx_act & ~txsh[7]);

    assign buf_wr    = scl_fall && (cnt == BIT_N) && (state == ST_WDATA);
    assign commit_go = stop_det & buf_any & ~wp_i & ~cm_act;
    assign cm_last   = cm_act && (cm_idx == {PG_W{1'b1}});
    assign buf_clr   = (start_det & ~cm_act) | (stop_det & ~commit_go & ~cm_act) | cm_last;

    // Commit sequencer and busy window after a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_act   <= 1'b0;
            cm_idx   <= '0;
            cm_page  <= '0;
            busy_cnt <= '0;
        end else if (commit_go) begin
            cm_act   <= 1'b1;
            cm_idx   <= '0;
            cm_page  <= page_q;
            busy_cnt <= BUSY_W'(BUSY_CYC);
        end else begin
            if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (cm_act) begin
                cm_idx <= cm_idx + 1'b1;
                if (cm_last) begin
                    cm_act <= 1'b0;
                end
            end
        end
    end

    eep_page_buf #(.PG_W(PG_W), .DW(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_idx    (addr_q[PG_W-1:0]),
        .wr_data   (shreg),
        .rd_idx    (cm_idx),
        .rd_data   (buf_rd),
        .rd_valid  (buf_vld),
        .any_valid (buf_any)
    );

    eep_array #(.AW(AW), .DW(8)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cm_act & buf_vld),
        .waddr ({cm_page, cm_idx}),
        .wdata (buf_rd),
        .raddr (addr_q),
        .rdata (rd_q)
    );

endmodule

// File: rtl/eep_slave_chk.sv
// Protocol checker bound to eep_slave. Observes ports plus a few state flags.
module eep_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic wp_i,
    input logic sda_oe_o,
    input logic busy,
    input logic cm_act,
    input logic st_idle,
    input logic st_dev
);
    // R4: the enable may only change while SCL is low.
    p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R3 / R10: an idle parser never pulls the line.
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !sda_oe_o);

    // R12: while busy, no select byte is answered.
    p_busy_nack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_dev) |-> !sda_oe_o);

    // R11: a commit only begins when write protect was low.
    p_wp_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cm_act) |-> !$past(wp_i));

    // R2: a STOP seen on the lines leaves the enable released.
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o);

endmodule

bind eep_slave eep_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .wp_i     (wp_i),
    .sda_oe_o (sda_oe_o),
    .busy     (busy),
    .cm_act   (cm_act),
    .st_idle  (st_idle),
    .st_dev   (st_dev)
);

// File: tb/tb_eep_slave.sv
`timescale 1ns/1ps
// Directed bench for eep_slave: a bit-level master model on a wired-AND bus.
module tb_eep_slave;
    localparam int H    = 10;
    localparam int BUSY = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl  [0:2047];
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];
    bit oe_seen;

    assign sda_line = ~(m_low | sda_oe);

    always #2 clk = ~clk;

    eep_slave #(.BUSY_CYC(BUSY)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wt(H);
        scl = 1'b1;   wt(H);
        m_low = 1'b1; wt(H);
        scl = 1'b0;   wt(H);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wt(H);
        scl = 1'b1;   wt(H);
        m_low = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wt(H);
            scl = 1'b1;    wt(H);
            if (sda_oe) oe_seen = 1'b1;
            scl = 1'b0;    wt(3);
        end
        m_low = 1'b0; wt(H);
        scl = 1'b1;   wt(1);
        a1 = ~sda_line; wt(H - 2);
        a2 = ~sda_line; wt(1);
        scl = 1'b0;   wt(3);
        ack = a1 & a2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        d = '0;
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            scl = 1'b1; wt(H / 2);
            d = {d[6:0], sda_line};
            wt(H - H / 2);
            scl = 1'b0;
        end
        wt(3);
        m_low = mack; wt(H);
        scl = 1'b1;   wt(H);
        scl = 1'b0;   wt(3);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] sel(input logic [2:0] seg, input bit rd);
        return {4'b1010, seg, rd};
    endfunction

    // Master write of n bytes from wbuf; returns the AND of all acknowledges.
    task automatic wr_seq(input logic [2:0] seg, input logic [7:0] off, input int n,
                          output bit allack);
        bit a;
        allack = 1'b1;
        i2c_start();
        send_byte(sel(seg, 1'b0), a); allack &= a;
        send_byte(off, a);            allack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); allack &= a;
        end
        i2c_stop();
    endtask

    function automatic void mdl_wr(input logic [2:0] seg, input logic [7:0] off, input int n);
        for (int i = 0; i < n; i++) begin
            logic [3:0] lo;
            lo = off[3:0] + 4'(i);
            mdl[{seg, off[7:4], lo}] = wbuf[i];
        end
    endfunction

    task automatic rd_rand(input logic [2:0] seg, input logic [7:0] off, input int n,
                           output bit allack);
        bit a;
        allack = 1'b1;
        i2c_start();
        send_byte(sel(seg, 1'b0), a); allack &= a;
        send_byte(off, a);            allack &= a;
        i2c_start();
        send_byte(sel(seg, 1'b1), a); allack &= a;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        i2c_stop();
    endtask

    task automatic rd_cur(input int n, output bit allack);
        bit a;
        i2c_start();
        send_byte(sel(3'd0, 1'b1), a); allack = a;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        i2c_stop();
    endtask

    task automatic t_byte_write();
        bit ok;
        oe_seen = 1'b0;
        wbuf[0] = 8'hA5;
        wr_seq(3'd3, 8'h25, 1, ok);
        mdl_wr(3'd3, 8'h25, 1);
        chk(ok, "R5", "byte write acks", ok, 1);
        chk(!oe_seen, "R4", "no drive during received bits", oe_seen, 0);
        wt(BUSY + 100);
        rd_rand(3'd3, 8'h25, 1, ok);
        chk(ok, "R2", "repeated start re-enters select stage", ok, 1);
        chk(rbuf[0] === 8'hA5, "R5", "byte read back", rbuf[0], 8'hA5);
    endtask

    task automatic t_bad_select();
        bit a0, a1, a2;
        bit ok;
        i2c_start();
        send_byte(8'hB6, a0);
        send_byte(8'h25, a1);
        send_byte(8'h00, a2);
        i2c_stop();
        chk(!a0, "R3", "foreign select not acked", a0, 0);
        chk(!a1 && !a2, "R3", "bytes after bad select ignored", {a1, a2}, 0);
        rd_rand(3'd3, 8'h25, 1, ok);
        chk(ok && rbuf[0] === 8'hA5, "R3", "memory untouched after bad select", rbuf[0], 8'hA5);
    endtask

    task automatic t_page_write();
        bit ok;
        bit good;
        for (int i = 0; i < 20; i++) wbuf[i] = 8'h40 + 8'(i);
        wr_seq(3'd5, 8'h3C, 20, ok);
        mdl_wr(3'd5, 8'h3C, 20);
        chk(ok, "R6", "page write acks", ok, 1);
        wt(BUSY + 100);
        rd_rand(3'd5, 8'h30, 16, ok);
        good = ok;
        for (int i = 0; i < 16; i++) begin
            chk(rbuf[i] === mdl[11'h530 + 11'(i)], "R6", "page slot after wrap",
                rbuf[i], mdl[11'h530 + 11'(i)]);
        end
        chk(good, "R8", "sequential read acks", good, 1);
    endtask

    task automatic t_current();
        bit ok;
        wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63;
        wr_seq(3'd1, 8'h10, 3, ok);
        mdl_wr(3'd1, 8'h10, 3);
        wt(BUSY + 100);
        rd_rand(3'd1, 8'h10, 1, ok);
        rd_cur(2, ok);
        chk(ok && rbuf[0] === 8'h62 && rbuf[1] === 8'h63, "R9",
            "current read continues after random read", {rbuf[0], rbuf[1]}, 16'h6263);
        wbuf[0] = 8'h71; wbuf[1] = 8'h72;
        wr_seq(3'd1, 8'h1E, 2, ok);
        mdl_wr(3'd1, 8'h1E, 2);
        wt(BUSY + 100);
        rd_cur(1, ok);
        chk(ok && rbuf[0] === mdl[11'h110], "R9", "current read after write wraps in page",
            rbuf[0], mdl[11'h110]);
    endtask

    task automatic t_rollover();
        bit ok;
        wbuf[0] = 8'hC3;
        wr_seq(3'd7, 8'hFF, 1, ok);
        mdl_wr(3'd7, 8'hFF, 1);
        wt(BUSY + 100);
        wbuf[0] = 8'h3C;
        wr_seq(3'd0, 8'h00, 1, ok);
        mdl_wr(3'd0, 8'h00, 1);
        wt(BUSY + 100);
        rd_rand(3'd7, 8'hFF, 2, ok);
        chk(ok && rbuf[0] === 8'hC3 && rbuf[1] === 8'h3C, "R8",
            "address rolls from 2047 to 0", {rbuf[0], rbuf[1]}, 16'hC33C);
    endtask

    task automatic t_restart_discard();
        bit ok;
        bit a;
        wbuf[0] = 8'h12;
        wr_seq(3'd2, 8'h40, 1, ok);
        mdl_wr(3'd2, 8'h40, 1);
        wt(BUSY + 100);
        i2c_start();
        send_byte(sel(3'd2, 1'b0), a);
        send_byte(8'h40, a);
        send_byte(8'h99, a);
        i2c_start();
        i2c_stop();
        rd_rand(3'd2, 8'h40, 1, ok);
        chk(ok, "R7", "no busy after discarded write", ok, 1);
        chk(rbuf[0] === 8'h12, "R7", "restart before stop drops data", rbuf[0], 8'h12);
    endtask

    task automatic t_wp();
        bit ok;
        wbuf[0] = 8'h21;
        wr_seq(3'd4, 8'h08, 1, ok);
        mdl_wr(3'd4, 8'h08, 1);
        wt(BUSY + 100);
        wp = 1'b1;
        wbuf[0] = 8'h77;
        wr_seq(3'd4, 8'h08, 1, ok);
        chk(ok, "R11", "protected write still acked", ok, 1);
        rd_rand(3'd4, 8'h08, 1, ok);
        chk(ok, "R11", "no busy window under protect", ok, 1);
        chk(rbuf[0] === 8'h21, "R11", "protected byte unchanged", rbuf[0], 8'h21);
        wp = 1'b0;
    endtask

    task automatic t_busy();
        bit ok;
        bit a;
        wbuf[0] = 8'h5A;
        wr_seq(3'd6, 8'h00, 1, ok);
        mdl_wr(3'd6, 8'h00, 1);
        i2c_start();
        send_byte(sel(3'd6, 1'b0), a);
        i2c_stop();
        chk(!a, "R12", "select refused while busy", a, 0);
        wt(BUSY + 100);
        rd_rand(3'd6, 8'h00, 1, ok);
        chk(ok && rbuf[0] === 8'h5A, "R12", "accepted after busy window", rbuf[0], 8'h5A);
    endtask

    task automatic t_nack();
        bit a;
        logic [7:0] d;
        i2c_start();
        send_byte(sel(3'd3, 1'b0), a);
        send_byte(8'h25, a);
        i2c_start();
        send_byte(sel(3'd3, 1'b1), a);
        recv_byte(1'b0, d);
        oe_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            wt(H);
            scl = 1'b1; wt(H);
            if (sda_oe) oe_seen = 1'b1;
            scl = 1'b0;
        end
        wt(3);
        chk(d === 8'hA5, "R10", "last byte before nack", d, 8'hA5);
        chk(!oe_seen, "R10", "line released after master nack", oe_seen, 0);
        i2c_stop();
        chk(!sda_oe, "R2", "released after stop", sda_oe, 0);
    endtask

    initial begin
        wt(5);
        chk(!sda_oe, "R1", "enable low during reset", sda_oe, 0);
        rst_n = 1'b1;
        wt(5);
        chk(!sda_oe && sda_line, "R1", "bus idle after reset", sda_oe, 0);
        t_byte_write();
        t_bad_select();
        t_page_write();
        t_current();
        t_rollover();
        t_restart_discard();
        t_wp();
        t_busy();
        t_nack();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule